// File: doc/BRIEF.md
# Software Xon/Xoff Flow Controller

This block handles in-band flow control for a serial link. It watches the stream of received characters for programmed stop (Xoff) and resume (Xon) codes. When it sees a stop code, it holds the local transmitter at the next character boundary, and it releases the transmitter when the resume code arrives. Matched codes are consumed by the block. Every other received character goes on to the receive buffer through the block's forwarding port. A code can be one character, or a pair of characters that must arrive back to back.

The block also sends flow control in the other direction. The receive FIFO's fill count and trigger level arrive as inputs. When the fill reaches the trigger, the block waits two character times and then asks the serializer to send the stop code. It asks for the resume code once the fill has fallen below one less than the trigger. One character time is the configured frame length counted in bit-time ticks.

The serializer and the FIFO sit outside this block. A sent flow-control character goes ahead of queued data, but it never interrupts a character that is already going out.

Top module: `sfc_flow_ctrl`

## Requirements
- R1: After reset, all four code registers are zero, and `tx_hold`, `ins_req`, `irq` and `buf_wr` are low. With receive matching on in single mode, a received 0x00 therefore acts as a stop code.
- R2: In single mode, a character equal to the stop code is not forwarded, and the block becomes suspended. Any other character is forwarded with `buf_wr` high in the cycle after its `rx_valid`.
- R3: In double mode, the first stop character followed directly by the second stop character suspends the block. Neither character is forwarded.
- R4: In double mode, if the first code character is followed by a character that does not complete the code, the held character is forwarded first and the new character after it. If the new character is itself the first code character, it becomes the new held character instead of being forwarded. Received characters arrive at least two cycles apart.
- R5: `tx_hold` rises for a suspension only in a cycle that follows a cycle with `tx_busy` low. While `tx_busy` stays high, `tx_hold` stays low.
- R6: A stop-code match sets `irq` only if `xoff_irq_en` is high. `irq_clr` clears `irq` without ending the suspension.
- R7: While suspended, a resume-code match is not forwarded. It ends the suspension, so `tx_hold` falls, and it clears `irq`. While suspended, a character equal to the stop code is forwarded as data.
- R8: With `rx_fc_en` low, every received character is forwarded and no suspension takes place.
- R9: When `auto_fc_en` is high and `rx_fill >= rx_trig`, `ins_req` rises after exactly 2×`frame_bits` `bit_tick` pulses, with `ins_data` equal to the first stop character. In double mode, the second stop character is requested after the first one is acknowledged.
- R10: After the stop code has been sent, the resume code is requested only when `rx_fill + 1 < rx_trig`. At `rx_fill = rx_trig - 1`, no request is made.
- R11: `ins_req` rises only after a cycle with `tx_busy` low, and it stays high until `ins_ack`. `tx_hold` is high while `ins_req` is high.
- R12: Writing with `reg_we` sets one code register, chosen by `reg_addr`: 0 first resume character, 1 second resume character, 2 first stop character, 3 second stop character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Code register write strobe |
| reg_addr | input | 2 | Code register select |
| reg_wdata | input | DATA_W | Code register write value |
| rx_fc_en | input | 1 | Enable matching of received codes |
| auto_fc_en | input | 1 | Enable automatic stop/resume sending |
| dbl_mode | input | 1 | 1: two-character codes, 0: one-character codes |
| xoff_irq_en | input | 1 | Allow a stop match to raise `irq` |
| irq_clr | input | 1 | Clear the interrupt flag |
| frame_bits | input | FRAME_W | Bits per character frame |
| bit_tick | input | 1 | One pulse per bit time |
| rx_fill | input | LVL_W | Receive FIFO fill count |
| rx_trig | input | LVL_W | Receive FIFO trigger level |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | DATA_W | Received character |
| buf_wr | output | 1 | Write forwarded character to receive buffer |
| buf_data | output | DATA_W | Forwarded character |
| tx_busy | input | 1 | Serializer is sending a character |
| tx_hold | output | 1 | Serializer must not start a data character |
| ins_req | output | 1 | Request to send a flow-control character |
| ins_data | output | DATA_W | Flow-control character to send |
| ins_ack | input | 1 | Serializer took the requested character |
| irq | output | 1 | Stop-code interrupt flag |

## Verification
The hardest case to reach is the released-pair path in double mode. A held first character has to be followed by a non-completing character, which forces two forwarded writes on back-to-back cycles. When that follower is itself a first code character, it forces a re-arm instead. The bench sends exact byte sequences (first code then a stranger, and first code twice then the second code) and logs every forwarded write in order. It uses the same approach for the hysteresis edge: it parks the fill exactly one below the trigger, waits, and only then drops it further. For the delay window, it counts single `bit_tick` pulses one at a time and checks that the request is still absent after the next-to-last tick.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
   // Code register select values (write address)
   typedef enum logic [1:0] {
      SEL_RESUME_A = 2'd0,
      SEL_RESUME_B = 2'd1,
      SEL_STOP_A   = 2'd2,
      SEL_STOP_B   = 2'd3
   } code_sel_t;

   // Automatic sender states
   typedef enum logic [2:0] {
      AS_RUN,
      AS_WAIT,
      AS_SEND_STOP,
      AS_STOPPED,
      AS_SEND_RESUME
   } auto_st_t;
endpackage

// File: rtl/sfc_code_regs.sv
module sfc_code_regs #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] resume_a,
   output logic [DATA_W-1:0] resume_b,
   output logic [DATA_W-1:0] stop_a,
   output logic [DATA_W-1:0] stop_b
);
   import sfc_pkg::*;
   localparam int NREG = 4;

   logic [DATA_W-1:0] code_q [NREG];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) code_q[i] <= '0;
      end else if (we) begin
         for (int i = 0; i < NREG; i++)
            if (addr == 2'(i)) code_q[i] <= wdata;
      end
   end

   assign resume_a = code_q[SEL_RESUME_A];
   assign resume_b = code_q[SEL_RESUME_B];
   assign stop_a   = code_q[SEL_STOP_A];
   assign stop_b   = code_q[SEL_STOP_B];
endmodule

// File: rtl/sfc_rx_match.sv
module sfc_rx_match #(
   parameter int DATA_W    = 8,
   parameter bit DOUBLE_OK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              dbl,
   input  logic              suspended,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   input  logic [DATA_W-1:0] resume_a,
   input  logic [DATA_W-1:0] resume_b,
   input  logic [DATA_W-1:0] stop_a,
   input  logic [DATA_W-1:0] stop_b,
   output logic              buf_wr,
   output logic [DATA_W-1:0] buf_data,
   output logic              stop_hit,
   output logic              resume_hit
);
   logic              dbl_eff;
   logic              held_q, pend_q;
   logic [DATA_W-1:0] held_data, pend_data;
   logic [DATA_W-1:0] want_a, want_b;

   generate
      if (DOUBLE_OK) begin : g_dbl
         assign dbl_eff = dbl;
      end else begin : g_single
         assign dbl_eff = 1'b0;
      end
   endgenerate

   assign want_a = suspended ? resume_a : stop_a;
   assign want_b = suspended ? resume_b : stop_b;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         buf_wr     <= 1'b0;
         buf_data   <= '0;
         stop_hit   <= 1'b0;
         resume_hit <= 1'b0;
         held_q     <= 1'b0;
         held_data  <= '0;
         pend_q     <= 1'b0;
         pend_data  <= '0;
      end else begin
         buf_wr     <= 1'b0;
         stop_hit   <= 1'b0;
         resume_hit <= 1'b0;
         if (pend_q) begin
            buf_wr   <= 1'b1;
            buf_data <= pend_data;
            pend_q   <= 1'b0;
         end
         if (rx_valid) begin
            if (!en) begin
               held_q   <= 1'b0;
               buf_wr   <= 1'b1;
               buf_data <= rx_data;
            end else if (!dbl_eff) begin
               held_q <= 1'b0;
               if (rx_data == want_a) begin
                  resume_hit <= suspended;
                  stop_hit   <= !suspended;
               end else begin
                  buf_wr   <= 1'b1;
                  buf_data <= rx_data;
               end
            end else if (!held_q) begin
               if (rx_data == want_a) begin
                  held_q    <= 1'b1;
                  held_data <= rx_data;
               end else begin
                  buf_wr   <= 1'b1;
                  buf_data <= rx_data;
               end
            end else begin
               held_q <= 1'b0;
               if (rx_data == want_b) begin
                  resume_hit <= suspended;
                  stop_hit   <= !suspended;
               end else begin
                  buf_wr   <= 1'b1;
                  buf_data <= held_data;
                  if (rx_data == want_a) begin
                     held_q    <= 1'b1;
                     held_data <= rx_data;
                  end else begin
                     pend_q    <= 1'b1;
                     pend_data <= rx_data;
                  end
               end
            end
         end
      end
   end

   // R2
   hit_not_forwarded_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_hit || resume_hit) |-> !buf_wr);
   // R4
   rx_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |-> !rx_valid);
endmodule

// File: rtl/sfc_char_timer.sv
module sfc_char_timer #(
   parameter int FRAME_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               tick,
   input  logic [FRAME_W-1:0] frame_bits,
   output logic               expire
);
   localparam int CW = FRAME_W + 1;

   logic          armed_q;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] last;

   // two character times, counted in bit ticks
   assign last   = {frame_bits, 1'b0} - CW'(1);
   assign expire = armed_q && tick && (cnt_q == last);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         cnt_q   <= '0;
      end else if (start) begin
         armed_q <= 1'b1;
         cnt_q   <= '0;
      end else if (expire) begin
         armed_q <= 1'b0;
      end else if (armed_q && tick) begin
         cnt_q <= cnt_q + CW'(1);
      end
   end

   // R9
   tick_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && $stable(frame_bits)) |-> (cnt_q <= last));
endmodule

// File: rtl/sfc_auto_send.sv
module sfc_auto_send #(
   parameter int DATA_W  = 8,
   parameter int LVL_W   = 5,
   parameter int FRAME_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               dbl,
   input  logic [LVL_W-1:0]   fill,
   input  logic [LVL_W-1:0]   trig,
   input  logic               bit_tick,
   input  logic [FRAME_W-1:0] frame_bits,
   input  logic               tx_busy,
   input  logic               ins_ack,
   input  logic [DATA_W-1:0]  resume_a,
   input  logic [DATA_W-1:0]  resume_b,
   input  logic [DATA_W-1:0]  stop_a,
   input  logic [DATA_W-1:0]  stop_b,
   output logic               ins_req,
   output logic [DATA_W-1:0]  ins_data
);
   import sfc_pkg::*;

   auto_st_t          st_q;
   logic              idx_q;
   logic              over, below, arm, expire, sending;
   logic [LVL_W:0]    fill_p1;
   logic [DATA_W-1:0] next_code;

   assign over    = fill >= trig;
   assign fill_p1 = {1'b0, fill} + (LVL_W+1)'(1);
   assign below   = fill_p1 < {1'b0, trig};
   assign arm     = en && (st_q == AS_RUN) && over;
   assign sending = (st_q == AS_SEND_STOP) || (st_q == AS_SEND_RESUME);

   always_comb begin
      if (st_q == AS_SEND_RESUME) next_code = idx_q ? resume_b : resume_a;
      else                        next_code = idx_q ? stop_b   : stop_a;
   end

   sfc_char_timer #(.FRAME_W(FRAME_W)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (arm),
      .tick       (bit_tick),
      .frame_bits (frame_bits),
      .expire     (expire)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= AS_RUN;
         idx_q    <= 1'b0;
         ins_req  <= 1'b0;
         ins_data <= '0;
      end else if (!en) begin
         st_q    <= AS_RUN;
         idx_q   <= 1'b0;
         ins_req <= 1'b0;
      end else begin
         if (sending && !ins_req && !tx_busy) begin
            ins_req  <= 1'b1;
            ins_data <= next_code;
         end
         if (sending && ins_req && ins_ack) begin
            ins_req <= 1'b0;
            if (dbl && !idx_q) begin
               idx_q <= 1'b1;
            end else begin
               idx_q <= 1'b0;
               st_q  <= (st_q == AS_SEND_STOP) ? AS_STOPPED : AS_RUN;
            end
         end
         unique case (st_q)
            AS_RUN:     if (over)   st_q <= AS_WAIT;
            AS_WAIT:    if (expire) begin st_q <= AS_SEND_STOP; idx_q <= 1'b0; end
            AS_STOPPED: if (below)  begin st_q <= AS_SEND_RESUME; idx_q <= 1'b0; end
            default: ;
         endcase
      end
   end

   // R11
   ins_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_req && !ins_ack && en) |=> ins_req);
   // R11
   ins_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ins_req) |-> !$past(tx_busy));
   // R10
   resume_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ins_req) && st_q == AS_SEND_RESUME && !idx_q) |-> !$past(over, 2));
endmodule

// File: rtl/sfc_flow_ctrl.sv
module sfc_flow_ctrl #(
   parameter int DATA_W    = 8,
   parameter int LVL_W     = 5,
   parameter int FRAME_W   = 4,
   parameter bit DOUBLE_OK = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_we,
   input  logic [1:0]         reg_addr,
   input  logic [DATA_W-1:0]  reg_wdata,
   input  logic               rx_fc_en,
   input  logic               auto_fc_en,
   input  logic               dbl_mode,
   input  logic               xoff_irq_en,
   input  logic               irq_clr,
   input  logic [FRAME_W-1:0] frame_bits,
   input  logic               bit_tick,
   input  logic [LVL_W-1:0]   rx_fill,
   input  logic [LVL_W-1:0]   rx_trig,
   input  logic               rx_valid,
   input  logic [DATA_W-1:0]  rx_data,
   output logic               buf_wr,
   output logic [DATA_W-1:0]  buf_data,
   input  logic               tx_busy,
   output logic               tx_hold,
   output logic               ins_req,
   output logic [DATA_W-1:0]  ins_data,
   input  logic               ins_ack,
   output logic               irq
);
   generate
      if (DATA_W < 1) begin : g_bad_data
         $error("DATA_W must be at least 1");
      end
      if (LVL_W < 1) begin : g_bad_lvl
         $error("LVL_W must be at least 1");
      end
      if (FRAME_W < 2) begin : g_bad_frame
         $error("FRAME_W must be at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] resume_a, resume_b, stop_a, stop_b;
   logic              stop_hit, resume_hit;
   logic              suspended_q, halted_q, irq_q;

   sfc_code_regs #(.DATA_W(DATA_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (reg_we),
      .addr     (reg_addr),
      .wdata    (reg_wdata),
      .resume_a (resume_a),
      .resume_b (resume_b),
      .stop_a   (stop_a),
      .stop_b   (stop_b)
   );

   sfc_rx_match #(.DATA_W(DATA_W), .DOUBLE_OK(DOUBLE_OK)) u_match (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (rx_fc_en),
      .dbl        (dbl_mode),
      .suspended  (suspended_q),
      .rx_valid   (rx_valid),
      .rx_data    (rx_data),
      .resume_a   (resume_a),
      .resume_b   (resume_b),
      .stop_a     (stop_a),
      .stop_b     (stop_b),
      .buf_wr     (buf_wr),
      .buf_data   (buf_data),
      .stop_hit   (stop_hit),
      .resume_hit (resume_hit)
   );

   sfc_auto_send #(.DATA_W(DATA_W), .LVL_W(LVL_W), .FRAME_W(FRAME_W)) u_auto (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (auto_fc_en),
      .dbl        (dbl_mode),
      .fill       (rx_fill),
      .trig       (rx_trig),
      .bit_tick   (bit_tick),
      .frame_bits (frame_bits),
      .tx_busy    (tx_busy),
      .ins_ack    (ins_ack),
      .resume_a   (resume_a),
      .resume_b   (resume_b),
      .stop_a     (stop_a),
      .stop_b     (stop_b),
      .ins_req    (ins_req),
      .ins_data   (ins_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         suspended_q <= 1'b0;
         halted_q    <= 1'b0;
         irq_q       <= 1'b0;
      end else begin
         if (!rx_fc_en || resume_hit) suspended_q <= 1'b0;
         else if (stop_hit)           suspended_q <= 1'b1;
         // stop only between characters
         halted_q <= suspended_q && (halted_q || !tx_busy);
         if (resume_hit || irq_clr)         irq_q <= 1'b0;
         else if (stop_hit && xoff_irq_en)  irq_q <= 1'b1;
      end
   end

   assign tx_hold = halted_q || ins_req;
   assign irq     = irq_q;

   // R5
   halt_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(halted_q) |-> !$past(tx_busy));
   // R6
   irq_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_q) |-> $past(xoff_irq_en));
   // R7
   resume_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resume_hit |=> ##1 !halted_q);
endmodule

// File: tb/sfc_flow_ctrl_tb.sv
module sfc_flow_ctrl_tb;
   localparam int DW = 8;
   localparam int LW = 5;
   localparam int FW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_we = 1'b0;
   logic [1:0]    reg_addr = '0;
   logic [DW-1:0] reg_wdata = '0;
   logic          rx_fc_en = 1'b0, auto_fc_en = 1'b0, dbl_mode = 1'b0;
   logic          xoff_irq_en = 1'b0, irq_clr = 1'b0;
   logic [FW-1:0] frame_bits = 4'd3;
   logic          bit_tick = 1'b0;
   logic [LW-1:0] rx_fill = '0, rx_trig = 5'd8;
   logic          rx_valid = 1'b0;
   logic [DW-1:0] rx_data = '0;
   logic          buf_wr, tx_hold, ins_req, irq;
   logic [DW-1:0] buf_data, ins_data;
   logic          tx_busy = 1'b0, ins_ack = 1'b0;

   int checks = 0;
   int errors = 0;
   logic [DW-1:0] log_mem [64];
   int log_n = 0;
   logic done = 1'b0;

   always #4 clk = ~clk;

   sfc_flow_ctrl #(.DATA_W(DW), .LVL_W(LW), .FRAME_W(FW)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .rx_fc_en(rx_fc_en), .auto_fc_en(auto_fc_en),
      .dbl_mode(dbl_mode), .xoff_irq_en(xoff_irq_en), .irq_clr(irq_clr),
      .frame_bits(frame_bits), .bit_tick(bit_tick), .rx_fill(rx_fill),
      .rx_trig(rx_trig), .rx_valid(rx_valid), .rx_data(rx_data),
      .buf_wr(buf_wr), .buf_data(buf_data), .tx_busy(tx_busy),
      .tx_hold(tx_hold), .ins_req(ins_req), .ins_data(ins_data),
      .ins_ack(ins_ack), .irq(irq)
   );

   always @(negedge clk) begin
      if (rst_n && buf_wr && log_n < 64) begin
         log_mem[log_n] = buf_data;
         log_n = log_n + 1;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      rx_fc_en = 0; auto_fc_en = 0; dbl_mode = 0; xoff_irq_en = 0;
      tx_busy = 0; ins_ack = 0; rx_fill = '0; rx_trig = 5'd8; frame_bits = 4'd3;
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
   endtask

   task automatic wr_code(input logic [1:0] a, input logic [DW-1:0] v);
      reg_we = 1'b1; reg_addr = a; reg_wdata = v;
      cyc(1);
      reg_we = 1'b0;
   endtask

   task automatic setup_codes();
      wr_code(2'd0, 8'h11); wr_code(2'd1, 8'h91);
      wr_code(2'd2, 8'h13); wr_code(2'd3, 8'h93);
   endtask

   // drive one character; reports buf_wr/buf_data seen the cycle after
   task automatic rx_char(input logic [DW-1:0] d, output logic wr, output logic [DW-1:0] dat);
      rx_valid = 1'b1; rx_data = d;
      cyc(1);
      rx_valid = 1'b0;
      wr = buf_wr; dat = buf_data;
      cyc(3);
   endtask

   task automatic tick_n(input int n);
      for (int i = 0; i < n; i++) begin
         bit_tick = 1'b1; cyc(1); bit_tick = 1'b0; cyc(1);
      end
   endtask

   task automatic ack();
      ins_ack = 1'b1; cyc(1); ins_ack = 1'b0; cyc(1);
   endtask

   task automatic t_reset();
      logic w; logic [DW-1:0] d; int n0;
      check(!tx_hold && !ins_req && !irq && !buf_wr, "R1 reset outputs", {tx_hold, ins_req, irq, buf_wr}, 0);
      rx_fc_en = 1;
      n0 = log_n;
      rx_char(8'h00, w, d);
      check(tx_hold == 1'b1, "R1 zero code stops", tx_hold, 1);
      check(log_n == n0, "R1 zero code not forwarded", log_n - n0, 0);
   endtask

   task automatic t_single();
      logic w; logic [DW-1:0] d; int n0;
      do_reset(); setup_codes();
      rx_fc_en = 1; xoff_irq_en = 1;
      rx_char(8'h41, w, d);
      check(w && d == 8'h41, "R2 data forwarded next cycle", {w, d}, {1'b1, 8'h41});
      n0 = log_n;
      rx_char(8'h13, w, d);
      check(tx_hold, "R12 R2 stop code suspends", tx_hold, 1);
      check(log_n == n0, "R2 stop not forwarded", log_n - n0, 0);
      check(irq, "R6 irq raised", irq, 1);
      rx_char(8'h13, w, d);
      check(w && d == 8'h13, "R7 stop while suspended is data", {w, d}, {1'b1, 8'h13});
      n0 = log_n;
      rx_char(8'h11, w, d);
      check(!tx_hold && !irq, "R7 resume releases", {tx_hold, irq}, 0);
      check(log_n == n0, "R7 resume not forwarded", log_n - n0, 0);
   endtask

   task automatic t_boundary();
      logic w; logic [DW-1:0] d;
      do_reset(); setup_codes();
      rx_fc_en = 1; tx_busy = 1;
      rx_char(8'h13, w, d);
      cyc(3);
      check(!tx_hold, "R5 no hold while busy", tx_hold, 0);
      tx_busy = 0;
      cyc(1);
      check(tx_hold, "R5 hold after char ends", tx_hold, 1);
   endtask

   task automatic t_irq();
      logic w; logic [DW-1:0] d;
      do_reset(); setup_codes();
      rx_fc_en = 1; xoff_irq_en = 0;
      rx_char(8'h13, w, d);
      check(!irq && tx_hold, "R6 irq masked", {irq, tx_hold}, 1);
      rx_char(8'h11, w, d);
      xoff_irq_en = 1;
      rx_char(8'h13, w, d);
      irq_clr = 1; cyc(1); irq_clr = 0; cyc(1);
      check(!irq && tx_hold, "R6 irq_clr keeps suspension", {irq, tx_hold}, 1);
   endtask

   task automatic t_double();
      logic w; logic [DW-1:0] d; int n0;
      do_reset(); setup_codes();
      rx_fc_en = 1; dbl_mode = 1;
      n0 = log_n;
      rx_char(8'h13, w, d);
      rx_char(8'h93, w, d);
      check(tx_hold && log_n == n0, "R3 pair suspends", {tx_hold, 8'(log_n - n0)}, {1'b1, 8'h00});
      rx_char(8'h11, w, d);
      rx_char(8'h91, w, d);
      check(!tx_hold, "R3 resume pair", tx_hold, 0);
      n0 = log_n;
      rx_char(8'h13, w, d);
      rx_char(8'h55, w, d);
      check(log_n == n0 + 2 && log_mem[n0] == 8'h13 && log_mem[n0+1] == 8'h55,
            "R4 held char released in order", log_n - n0, 2);
      n0 = log_n;
      rx_char(8'h13, w, d);
      rx_char(8'h13, w, d);
      rx_char(8'h93, w, d);
      check(log_n == n0 + 1 && log_mem[n0] == 8'h13 && tx_hold,
            "R4 re-armed first char", log_n - n0, 1);
   endtask

   task automatic t_disabled();
      logic w; logic [DW-1:0] d;
      do_reset(); setup_codes();
      rx_fc_en = 0;
      rx_char(8'h13, w, d);
      check(w && d == 8'h13 && !tx_hold, "R8 matching off forwards", {w, d}, {1'b1, 8'h13});
   endtask

   task automatic t_auto();
      do_reset(); setup_codes();
      auto_fc_en = 1; frame_bits = 4'd3; rx_trig = 5'd8; rx_fill = 5'd8;
      cyc(2);
      tick_n(5); cyc(3);
      check(!ins_req, "R9 no request before 2 char times", ins_req, 0);
      tick_n(1); cyc(1);
      check(ins_req && ins_data == 8'h13, "R9 stop sent after 6 ticks", {ins_req, ins_data}, {1'b1, 8'h13});
      check(tx_hold, "R11 hold while inserting", tx_hold, 1);
      cyc(3);
      check(ins_req, "R11 request held until ack", ins_req, 1);
      ack(); cyc(2);
      check(!ins_req, "R9 single stop only", ins_req, 0);
      rx_fill = 5'd7; cyc(6);
      check(!ins_req, "R10 no resume at trig-1", ins_req, 0);
      rx_fill = 5'd6; cyc(3);
      check(ins_req && ins_data == 8'h11, "R10 resume below trig-1", {ins_req, ins_data}, {1'b1, 8'h11});
      ack();
      tx_busy = 1; rx_fill = 5'd9; cyc(2);
      tick_n(6); cyc(4);
      check(!ins_req, "R11 waits for busy char", ins_req, 0);
      tx_busy = 0; cyc(2);
      check(ins_req && ins_data == 8'h13, "R11 sends after char", {ins_req, ins_data}, {1'b1, 8'h13});
      ack();
   endtask

   task automatic t_auto_double();
      do_reset(); setup_codes();
      auto_fc_en = 1; dbl_mode = 1; frame_bits = 4'd2; rx_fill = 5'd10;
      cyc(2);
      tick_n(4); cyc(2);
      check(ins_req && ins_data == 8'h13, "R9 double first stop", {ins_req, ins_data}, {1'b1, 8'h13});
      ack(); cyc(1);
      check(ins_req && ins_data == 8'h93, "R9 double second stop", {ins_req, ins_data}, {1'b1, 8'h93});
      ack();
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #100000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=0x0 expected=0x1");
         finish_run();
      end
   end

   initial begin
      cyc(4);
      rst_n = 1'b1;
      cyc(1);
      t_reset();
      t_single();
      t_boundary();
      t_irq();
      t_double();
      t_disabled();
      t_auto();
      t_auto_double();
      done = 1'b1;
      finish_run();
   end
endmodule